// File: doc/BRIEF.md
# Cache Store Buffer

This block sits between the tag-check stage of a two-way set-associative data cache and its data array. When the tag check reports a store hit, the block records where the store lands (set index, way, word within the line) together with the store data and its byte enables, and acknowledges the store at once. The data array is written later, from the oldest recorded store, in a cycle when the array is not serving a read. Reads therefore keep priority over store updates, and a store hit does not have to wait for a free array cycle.

Loads that read the array while stores are still pending look up the buffer in parallel. Every pending store whose set index, way and word match the load overlays its enabled bytes on the word read from the array. The overlay is applied oldest first, so the youngest store wins on each byte. A store that lands on the same word as the youngest pending store is merged into that entry rather than taking a new one. When all entries are in use and a new store cannot be merged, the store is stalled. If pending stores see no idle array cycle for a set number of cycles, the block takes the array for one forced write.

The control is a three-state machine. `SB_EMPTY` means no store is pending and there are no writes. `SB_WAIT` means stores are pending, and the head entry is written in any idle array cycle. `SB_FORCE` makes one write of the head entry whatever the array is doing. The transitions are:
- push: `SB_EMPTY` to `SB_WAIT` on an accepted store.
- drained: `SB_WAIT` or `SB_FORCE` to `SB_EMPTY` when the last entry is written and no store arrives.
- starved: `SB_WAIT` to `SB_FORCE` after `STARVE_LIMIT` consecutive busy cycles.
- resume: `SB_FORCE` to `SB_WAIT` when entries remain after the forced write.

Top module: `cache_store_buffer`

## Requirements
- R1: After reset the buffer is empty. `arr_wr_en`, `arr_wr_forced`, `st_stall` and `ld_fwd_hit` are 0, and `ld_data` equals `ld_arr_data`.
- R2: An accepted store hit becomes visible to loads in the cycle after it is presented. A load with the same index, way and word then returns the stored bytes.
- R3: Only bytes whose enable bit is set are affected. Bit b of a byte-enable field covers data bits [8b+7:8b]. The array write port presents the entry's accumulated enables on `arr_wr_be`.
- R4: With `arr_idle` at 0, the array is written only by a forced write (`arr_wr_forced` is 1). With `arr_idle` at 1 and a store pending, the head entry is written in that cycle.
- R5: Entries are written to the array in the order they were accepted, one per write cycle, and a write occurs only while an entry is pending.
- R6: On a load, every pending entry matching index, way and word overlays its enabled bytes on `ld_arr_data`, and the youngest wins on each byte. `ld_fwd_hit` is 1 when any entry matched.
- R7: With `DEPTH` (default 4) entries pending, a store that does not match the youngest entry raises `st_stall` combinationally and is not recorded. The entry count never exceeds `DEPTH`.
- R8: After `STARVE_LIMIT` (default 8) consecutive cycles with stores pending and no write, the next cycle writes the head entry with `arr_wr_forced` at 1.
- R9: A store matching the youngest pending entry in index, way and word merges into that entry. Its enabled bytes replace the old ones and the enables are OR-ed. The merge takes no new entry and is never stalled, unless that entry is also being written in the same cycle, in which case the store takes a new entry.
- R10: A load differing from a pending entry in any of index, way or word gets no bytes from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_hit_valid | input | 1 | Tag stage reports a store hit this cycle |
| st_index | input | 10 | Set index of the store |
| st_way | input | 1 | Way that hit |
| st_word | input | 2 | 32-bit word within the 16-byte line |
| st_data | input | 32 | Store data |
| st_be | input | 4 | Byte enables of the store |
| st_stall | output | 1 | Store not accepted this cycle, must be re-presented |
| arr_idle | input | 1 | Data array has no read in this cycle |
| arr_wr_en | output | 1 | Write the data array this cycle |
| arr_wr_forced | output | 1 | The current write is a forced drain |
| arr_wr_index | output | 10 | Set index of the array write |
| arr_wr_way | output | 1 | Way of the array write |
| arr_wr_word | output | 2 | Word of the array write |
| arr_wr_data | output | 32 | Write data |
| arr_wr_be | output | 4 | Byte enables of the array write |
| ld_valid | input | 1 | A load reads the array this cycle |
| ld_index | input | 10 | Set index of the load |
| ld_way | input | 1 | Way of the load |
| ld_word | input | 2 | Word of the load |
| ld_arr_data | input | 32 | Word read from the array |
| ld_data | output | 32 | Load data with pending bytes merged in |
| ld_fwd_hit | output | 1 | At least one pending entry matched the load |

## Verification
The write port, the stall and the load merge are combinational in the current inputs and buffer contents, so they are due in the same cycle the inputs are driven. A store accepted at a clock edge shows up in lookups and becomes eligible for the write port from the next cycle on. The bench drives inputs on the falling edge, compares every output a short delay later against a queue-based reference model, and advances that model only at the following rising edge. The forced drain is predicted by a busy-cycle counter in the model, so its cycle is known exactly.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int IDX_W  = 10;
    localparam int WAY_W  = 1;
    localparam int WORD_W = 2;
    localparam int DATA_W = 32;
    localparam int BE_W   = DATA_W / 8;

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [WAY_W-1:0]  way;
        logic [WORD_W-1:0] word;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } sb_entry_t;

    typedef enum logic [1:0] {
        SB_EMPTY = 2'd0,
        SB_WAIT  = 2'd1,
        SB_FORCE = 2'd2
    } sb_state_e;
endpackage

// File: rtl/sb_fifo.sv
// Entry storage: circular queue with merge into the youngest entry.
module sb_fifo
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   st_valid,
    input  sb_entry_t              st_ent,
    input  logic                   pop,
    output logic                   push,
    output logic                   stall,
    output sb_entry_t              head_ent,
    output sb_entry_t [DEPTH-1:0]  ents,
    output logic [PTR_W-1:0]       head_ptr,
    output logic [CNT_W-1:0]       occ
);
    sb_entry_t [DEPTH-1:0] mem_q;
    logic [PTR_W-1:0] head_q, tail_q, young;
    logic [CNT_W-1:0] occ_q;
    logic young_hit, merge, full;

    assign young     = tail_q - PTR_W'(1);
    assign young_hit = (occ_q != '0)
                     && (mem_q[young].idx  == st_ent.idx)
                     && (mem_q[young].way  == st_ent.way)
                     && (mem_q[young].word == st_ent.word);
    // the youngest entry cannot absorb a store while it is leaving
    assign merge = st_valid && young_hit && !((occ_q == CNT_W'(1)) && pop);
    assign full  = (occ_q == CNT_W'(DEPTH));
    assign stall = st_valid && full && !young_hit;
    assign push  = st_valid && !merge && !stall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            if (merge) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (st_ent.be[b])
                        mem_q[young].data[b*8 +: 8] <= st_ent.data[b*8 +: 8];
                end
                mem_q[young].be <= mem_q[young].be | st_ent.be;
            end
            if (push) begin
                mem_q[tail_q] <= st_ent;
                tail_q        <= tail_q + PTR_W'(1);
            end
            if (pop) head_q <= head_q + PTR_W'(1);
            occ_q <= occ_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_ent = mem_q[head_q];
    assign ents     = mem_q;
    assign head_ptr = head_q;
    assign occ      = occ_q;
endmodule

// File: rtl/sb_ctrl.sv
// Drain control: decides when the head entry is written to the array.
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter int STARVE_LIMIT = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int STV_W = $clog2(STARVE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arr_idle,
    input  logic             push,
    input  logic [CNT_W-1:0] occ,
    output logic             wr_en,
    output logic             forced
);
    sb_state_e state_q, state_d;
    logic [STV_W-1:0] starve_q;
    logic drains_out, starved;

    assign drains_out = (occ == CNT_W'(1)) && wr_en && !push;
    assign starved    = !arr_idle && (starve_q == STV_W'(STARVE_LIMIT - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SB_EMPTY;
        else        state_q <= state_d;
    end

    // busy-cycle counter while waiting
    always_ff @(posedge clk) begin
        if (!rst_n)                             starve_q <= '0;
        else if (state_q == SB_WAIT && !arr_idle) starve_q <= starve_q + STV_W'(1);
        else                                    starve_q <= '0;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SB_EMPTY: state_d = push ? SB_WAIT : SB_EMPTY;
            SB_WAIT: begin
                if (drains_out)   state_d = SB_EMPTY;
                else if (starved) state_d = SB_FORCE;
                else              state_d = SB_WAIT;
            end
            SB_FORCE: state_d = drains_out ? SB_EMPTY : SB_WAIT;
            default:  state_d = SB_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        wr_en  = 1'b0;
        forced = 1'b0;
        unique case (state_q)
            SB_EMPTY: begin
                wr_en  = 1'b0;
                forced = 1'b0;
            end
            SB_WAIT: begin
                wr_en  = arr_idle;
                forced = 1'b0;
            end
            SB_FORCE: begin
                wr_en  = 1'b1;
                forced = 1'b1;
            end
            default: begin
                wr_en  = 1'b0;
                forced = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sb_fwd.sv
// Load lookup: overlays matching pending bytes, oldest first.
module sb_fwd
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  sb_entry_t [DEPTH-1:0] ents,
    input  logic [PTR_W-1:0]      head_ptr,
    input  logic [CNT_W-1:0]      occ,
    input  logic                  ld_valid,
    input  logic [IDX_W-1:0]      ld_index,
    input  logic [WAY_W-1:0]      ld_way,
    input  logic [WORD_W-1:0]     ld_word,
    input  logic [DATA_W-1:0]     arr_data,
    output logic [DATA_W-1:0]     data,
    output logic                  hit
);
    logic [DEPTH-1:0] match;

    // match vector indexed by age (0 = oldest)
    for (genvar a = 0; a < DEPTH; a++) begin : g_age
        logic [PTR_W-1:0] slot;
        assign slot     = head_ptr + PTR_W'(a);
        assign match[a] = ld_valid && (CNT_W'(a) < occ)
                        && (ents[slot].idx  == ld_index)
                        && (ents[slot].way  == ld_way)
                        && (ents[slot].word == ld_word);
    end

    always_comb begin
        data = arr_data;
        for (int a = 0; a < DEPTH; a++) begin
            if (match[a]) begin
                for (int b = 0; b < BE_W; b++) begin
                    if (ents[head_ptr + PTR_W'(a)].be[b])
                        data[b*8 +: 8] = ents[head_ptr + PTR_W'(a)].data[b*8 +: 8];
                end
            end
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cache_store_buffer.sv
module cache_store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH        = 4,
    parameter int STARVE_LIMIT = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_hit_valid,
    input  logic [IDX_W-1:0]  st_index,
    input  logic [WAY_W-1:0]  st_way,
    input  logic [WORD_W-1:0] st_word,
    input  logic [DATA_W-1:0] st_data,
    input  logic [BE_W-1:0]   st_be,
    output logic              st_stall,
    input  logic              arr_idle,
    output logic              arr_wr_en,
    output logic              arr_wr_forced,
    output logic [IDX_W-1:0]  arr_wr_index,
    output logic [WAY_W-1:0]  arr_wr_way,
    output logic [WORD_W-1:0] arr_wr_word,
    output logic [DATA_W-1:0] arr_wr_data,
    output logic [BE_W-1:0]   arr_wr_be,
    input  logic              ld_valid,
    input  logic [IDX_W-1:0]  ld_index,
    input  logic [WAY_W-1:0]  ld_way,
    input  logic [WORD_W-1:0] ld_word,
    input  logic [DATA_W-1:0] ld_arr_data,
    output logic [DATA_W-1:0] ld_data,
    output logic              ld_fwd_hit
);
    sb_entry_t             st_ent, head_ent;
    sb_entry_t [DEPTH-1:0] ents;
    logic [PTR_W-1:0]      head_ptr;
    logic [CNT_W-1:0]      occ;
    logic                  push, wr_en, forced;

    assign st_ent = '{idx: st_index, way: st_way, word: st_word,
                      data: st_data, be: st_be};

    sb_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .st_valid (st_hit_valid),
        .st_ent   (st_ent),
        .pop      (wr_en),
        .push     (push),
        .stall    (st_stall),
        .head_ent (head_ent),
        .ents     (ents),
        .head_ptr (head_ptr),
        .occ      (occ)
    );

    sb_ctrl #(.DEPTH(DEPTH), .STARVE_LIMIT(STARVE_LIMIT)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arr_idle (arr_idle),
        .push     (push),
        .occ      (occ),
        .wr_en    (wr_en),
        .forced   (forced)
    );

    sb_fwd #(.DEPTH(DEPTH)) fwd_i (
        .ents     (ents),
        .head_ptr (head_ptr),
        .occ      (occ),
        .ld_valid (ld_valid),
        .ld_index (ld_index),
        .ld_way   (ld_way),
        .ld_word  (ld_word),
        .arr_data (ld_arr_data),
        .data     (ld_data),
        .hit      (ld_fwd_hit)
    );

    assign arr_wr_en     = wr_en;
    assign arr_wr_forced = forced;
    assign arr_wr_index  = head_ent.idx;
    assign arr_wr_way    = head_ent.way;
    assign arr_wr_word   = head_ent.word;
    assign arr_wr_data   = head_ent.data;
    assign arr_wr_be     = head_ent.be;
endmodule

// File: rtl/cache_store_buffer_chk.sv
module cache_store_buffer_chk #(
    parameter int DEPTH        = 4,
    parameter int STARVE_LIMIT = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int WIN_W = $clog2(STARVE_LIMIT + 2) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             st_hit_valid,
    input logic             st_stall,
    input logic             arr_idle,
    input logic             arr_wr_en,
    input logic             arr_wr_forced,
    input logic [CNT_W-1:0] occ
);
    logic [WIN_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)                         wait_cnt <= '0;
        else if (occ != '0 && !arr_wr_en)   wait_cnt <= wait_cnt + WIN_W'(1);
        else                                wait_cnt <= '0;
    end

    assert_wr_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr_en && !arr_idle) |-> arr_wr_forced);

    assert_forced_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_forced |-> arr_wr_en);

    assert_starve_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt <= WIN_W'(STARVE_LIMIT));

    assert_wr_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_wr_en |-> (occ != '0));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_stall_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_stall |-> (st_hit_valid && occ == CNT_W'(DEPTH)));

    assert_stall_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_stall && !arr_wr_en) |=> (occ == CNT_W'(DEPTH)));
endmodule

bind cache_store_buffer cache_store_buffer_chk #(
    .DEPTH(DEPTH), .STARVE_LIMIT(STARVE_LIMIT)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_hit_valid  (st_hit_valid),
    .st_stall      (st_stall),
    .arr_idle      (arr_idle),
    .arr_wr_en     (arr_wr_en),
    .arr_wr_forced (arr_wr_forced),
    .occ           (occ)
);

// File: tb/cache_store_buffer_tb_top.sv
`timescale 1ns/100ps
module cache_store_buffer_tb_top;
    import sb_pkg::*;
    localparam int DEPTH = 4;
    localparam int LIMIT = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_hit_valid = 1'b0;
    logic [IDX_W-1:0] st_index = '0;
    logic [WAY_W-1:0] st_way = '0;
    logic [WORD_W-1:0] st_word = '0;
    logic [DATA_W-1:0] st_data = '0;
    logic [BE_W-1:0] st_be = '0;
    logic st_stall, arr_wr_en, arr_wr_forced, ld_fwd_hit;
    logic arr_idle = 1'b0;
    logic [IDX_W-1:0] arr_wr_index;
    logic [WAY_W-1:0] arr_wr_way;
    logic [WORD_W-1:0] arr_wr_word;
    logic [DATA_W-1:0] arr_wr_data, ld_data;
    logic [BE_W-1:0] arr_wr_be;
    logic ld_valid = 1'b0;
    logic [IDX_W-1:0] ld_index = '0;
    logic [WAY_W-1:0] ld_way = '0;
    logic [WORD_W-1:0] ld_word = '0;
    logic [DATA_W-1:0] ld_arr_data = '0;

    always #2 clk = ~clk;

    cache_store_buffer #(.DEPTH(DEPTH), .STARVE_LIMIT(LIMIT)) dut_i (.*);

    int n_chk = 0, n_fail = 0, forced_seen = 0;
    sb_entry_t q[$];
    int busy_cnt = 0;
    bit force_m = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit same_loc(sb_entry_t e, logic [IDX_W-1:0] i, logic [WAY_W-1:0] w, logic [WORD_W-1:0] d);
        return (e.idx == i) && (e.way == w) && (e.word == d);
    endfunction

    function automatic logic [DATA_W:0] fwd_exp();
        logic [DATA_W-1:0] r = ld_arr_data;
        logic h = 1'b0;
        foreach (q[a]) begin
            if (same_loc(q[a], ld_index, ld_way, ld_word)) begin
                h = 1'b1;
                for (int b = 0; b < BE_W; b++)
                    if (q[a].be[b]) r[b*8 +: 8] = q[a].data[b*8 +: 8];
            end
        end
        return {h, r};
    endfunction

    // compare all outputs, then advance the model at the rising edge
    task automatic run_cycle();
        bit en_e, forced_e, ymatch, stall_e, merge_e, push_e;
        logic [DATA_W:0] fe;
        sb_entry_t hd, ne;
        en_e     = (q.size() > 0) && (arr_idle || force_m);
        forced_e = (q.size() > 0) && force_m;
        ymatch   = (q.size() > 0) && same_loc(q[$], st_index, st_way, st_word);
        stall_e  = st_hit_valid && (q.size() == DEPTH) && !ymatch;
        merge_e  = st_hit_valid && ymatch && !(q.size() == 1 && en_e);
        push_e   = st_hit_valid && !merge_e && !stall_e;
        if (arr_wr_forced === 1'b1) forced_seen++;
        chk(arr_wr_en === en_e, "R4 wr_en", 64'(arr_wr_en), 64'(en_e));
        chk(arr_wr_forced === forced_e, "R8 forced", 64'(arr_wr_forced), 64'(forced_e));
        if (en_e) begin
            hd = q[0];
            chk({arr_wr_index, arr_wr_way, arr_wr_word, arr_wr_data} ===
                {hd.idx, hd.way, hd.word, hd.data}, "R5 write entry",
                64'({arr_wr_index, arr_wr_way, arr_wr_word, arr_wr_data}),
                64'({hd.idx, hd.way, hd.word, hd.data}));
            chk(arr_wr_be === hd.be, "R3 write be", 64'(arr_wr_be), 64'(hd.be));
        end
        chk(st_stall === stall_e, "R7 stall", 64'(st_stall), 64'(stall_e));
        if (ld_valid) begin
            fe = fwd_exp();
            chk({ld_fwd_hit, ld_data} === fe, "R6 load merge",
                64'({ld_fwd_hit, ld_data}), 64'(fe));
        end
        @(posedge clk);
        if (en_e) begin
            busy_cnt = 0;
            force_m  = 0;
        end else if (q.size() > 0) begin
            busy_cnt++;
            if (busy_cnt == LIMIT) force_m = 1;
        end else busy_cnt = 0;
        if (merge_e) begin
            for (int b = 0; b < BE_W; b++)
                if (st_be[b]) q[$].data[b*8 +: 8] = st_data[b*8 +: 8];
            q[$].be = q[$].be | st_be;
        end
        if (en_e) void'(q.pop_front());
        if (push_e) begin
            ne = '{idx: st_index, way: st_way, word: st_word, data: st_data, be: st_be};
            q.push_back(ne);
        end
        @(negedge clk);
    endtask

    task automatic drive_st(input bit v, input int idx, input bit w, input int wd,
                            input logic [31:0] d, input logic [3:0] be);
        st_hit_valid = v;
        st_index = IDX_W'(idx);
        st_way = w;
        st_word = WORD_W'(wd);
        st_data = d;
        st_be = be;
    endtask

    task automatic drive_ld(input bit v, input int idx, input bit w, input int wd, input logic [31:0] a);
        ld_valid = v;
        ld_index = IDX_W'(idx);
        ld_way = w;
        ld_word = WORD_W'(wd);
        ld_arr_data = a;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int unsigned seed0;
        seed0 = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive_ld(1, 5, 0, 1, 32'hCAFE0001);
        #1;
        // R1: empty after reset
        chk({arr_wr_en, arr_wr_forced, st_stall, ld_fwd_hit} === 4'b0, "R1 idle outputs",
            64'({arr_wr_en, arr_wr_forced, st_stall, ld_fwd_hit}), 64'(0));
        chk(ld_data === 32'hCAFE0001, "R1 passthrough", 64'(ld_data), 64'h0CAFE0001);
        run_cycle();

        arr_idle = 0;
        drive_ld(0, 0, 0, 0, 0);
        drive_st(1, 5, 0, 1, 32'hAABBCCDD, 4'hF);
        #1; run_cycle();
        drive_st(1, 5, 0, 1, 32'h00000011, 4'h1);
        drive_ld(1, 5, 0, 1, 32'h0);
        #1;
        chk(ld_data === 32'hAABBCCDD && ld_fwd_hit, "R2 store visible", 64'(ld_data), 64'hAABBCCDD);
        run_cycle();
        drive_st(0, 0, 0, 0, 0, 0);
        #1;
        chk(ld_data === 32'hAABBCC11, "R9 merged byte", 64'(ld_data), 64'hAABBCC11);
        run_cycle();
        drive_ld(1, 5, 1, 1, 32'h12345678);
        #1;
        chk(ld_data === 32'h12345678 && !ld_fwd_hit, "R10 way mismatch", 64'({ld_fwd_hit, ld_data}), 64'h12345678);
        run_cycle();
        drive_ld(1, 5, 0, 2, 32'h0BADF00D);
        #1;
        chk(ld_data === 32'h0BADF00D && !ld_fwd_hit, "R10 word mismatch", 64'({ld_fwd_hit, ld_data}), 64'h0BADF00D);
        drive_st(1, 6, 0, 0, 32'h66666666, 4'hF);
        run_cycle();
        drive_st(1, 7, 0, 0, 32'h77777777, 4'hF);
        #1; run_cycle();
        drive_st(1, 8, 0, 0, 32'h88888888, 4'hF);
        #1; run_cycle();
        drive_st(1, 9, 0, 0, 32'h99999999, 4'hF);
        #1;
        chk(st_stall === 1'b1, "R7 full stall", 64'(st_stall), 64'(1));
        run_cycle();
        drive_st(0, 0, 0, 0, 0, 0);
        repeat (30) begin #1; run_cycle(); end
        chk(forced_seen > 0, "R8 forced drain seen", 64'(forced_seen), 64'(1));
        arr_idle = 1;
        repeat (6) begin #1; run_cycle(); end

        arr_idle = 0;
        drive_st(1, 3, 1, 3, 32'h55667788, 4'b0101);
        #1; run_cycle();
        drive_st(0, 0, 0, 0, 0, 0);
        arr_idle = 1;
        #1;
        chk(arr_wr_en && arr_wr_be === 4'b0101 && arr_wr_data === 32'h55667788,
            "R3 partial enables", 64'({arr_wr_be, arr_wr_data}), 64'({4'b0101, 32'h55667788}));
        run_cycle();

        for (int c = 0; c < 4000; c++) begin
            int busy_pct;
            busy_pct = ((c / 200) % 2 == 0) ? 90 : 50;
            arr_idle = ($urandom % 100) >= busy_pct;
            drive_st(($urandom % 2) == 0,
                     (($urandom % 4) == 0) ? 1023 : int'($urandom % 3),
                     1'($urandom), int'($urandom % 4), $urandom, 4'(($urandom % 15) + 1));
            drive_ld(($urandom % 2) == 0,
                     (($urandom % 4) == 0) ? 1023 : int'($urandom % 3),
                     1'($urandom), int'($urandom % 4), $urandom);
            #1; run_cycle();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule